// File: doc/BRIEF.md
# Multi-Channel Match PWM Timer

This block is a timer and counter with a prescaler. It drives six pulse-width outputs from seven match registers. Match register 0 sets the repetition period shared by every output. Each of outputs 2 to 6 can be single-edge or double-edge. In single-edge mode the output rises at the start of a period and falls at its own match. In double-edge mode the output is set by the match just below its own index and cleared by its own match, which gives a positive-going or a negative-going pulse. Output 1 is always single-edge.

Every match register can raise an interrupt flag, reset the counter or stop the counter when the count equals its value. The counter advances by one each time the prescaler reaches its limit. The prescaler counts either every clock or every synchronized rising edge of an external capture pin.

Match values are written to shadow copies and do nothing until software sets that register's release bit. While the counter is running, a released value moves to the active comparator only on the clock at which the count wraps from the period value to zero. When the counter is not running, the move happens on the next clock. When PWM mode is off, all outputs stay low and the block works as a plain timer.

A controller with three states decides whether counting happens:
- ST_IDLE waits for the enable bit and goes to ST_RUN when the enable bit is 1.
- ST_RUN counts. It returns to ST_IDLE when the enable bit is cleared, and goes to ST_HALT when a match event has its stop action enabled.
- ST_HALT holds the counter and returns to ST_IDLE once the enable bit is cleared.

The register map uses word addresses:
- 0: control. Bit 0 enables counting, bit 1 holds the counter and prescaler at zero, bit 2 selects PWM mode and bit 3 selects the capture pin as the count source.
- 1: prescaler limit.
- 2: count value (read only).
- 3: prescaler count (read only).
- 4: match actions, three bits per match register i. Bit 3i raises an interrupt, bit 3i+1 resets the counter and bit 3i+2 stops it.
- 5: edge mode, where bit k-1 makes output k double-edge.
- 6: release bits. Writing sets them, and each reads 1 while pending.
- 7: interrupt flags, write 1 to clear.
- 8 to 14: shadow match registers 0 to 6.
- 16 to 22: active match registers 0 to 6 (read only).

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads 0, the count is 0, all PWM outputs are low and irq is low.
- R2: With the clock as source (control bit 3 = 0), the count rises by exactly one every prescaler limit + 1 clocks while running.
- R3: With control bit 3 = 1, the prescaler counts only rising edges of cap_in after a two-flop synchronizer. A level held high for many clocks counts once.
- R4: In PWM mode (control bit 2 = 1), the count runs 0 up to the active value of match 0 and then returns to 0 on the next advance.
- R5: A single-edge output is set when the count wraps from match 0 to zero and cleared on the advance from a count equal to its own match value.
- R6: Double-edge output k (edge bit k-1 = 1, k from 2 to 6) is set on the advance from count = match k-1 and cleared on the advance from count = match k. This gives a positive or a negative pulse depending on the order of the two values.
- R7: When the set and clear of an output fall on the same advance, clear wins. A single-edge output whose match equals match 0 stays low, and one whose match exceeds match 0 stays high.
- R8: Output 1 is always single-edge: edge bit 0 is ignored and reads 0.
- R9: A shadow write leaves the active value unchanged until the release bit is set. While running, the transfer happens only on the wrap to zero. While not running, it happens on the next clock. The release bit self-clears on transfer.
- R10: A match whose reset action (bit 3i+1) is set returns the count to 0 on the advance from that value.
- R11: A match whose stop action (bit 3i+2) is set freezes the count at that value until the enable bit is cleared.
- R12: A match whose interrupt action (bit 3i) is set raises flag i in register 7 and irq. Writing 1 to flag i clears it.
- R13: With PWM mode off, all outputs stay low while the counter and match actions keep working.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_in | input | 1 | External count source, asynchronous |
| pwm_out | output | 6 | PWM outputs 1 to 6 (bit k-1 is output k) |
| irq | output | 1 | High while any interrupt flag is set |

## Verification
The hardest case to reach from the ports is a released shadow value landing while the counter is mid-period. The transfer must wait for the exact clock at which the count wraps, and nothing visible happens before that clock. The stimulus starts a running PWM period, writes a new shadow value and releases it at an arbitrary point in the period. It then polls the active copy every clock and requires that the first clock showing the new value also shows a count of zero. Random runs mix single-edge and double-edge channels with match values below, equal to and above the period, and compare every output against an event model of the requirements on each clock.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tmr_state_e;

    // bit offsets inside one match-action group
    localparam int ACT_INT  = 0;
    localparam int ACT_RST  = 1;
    localparam int ACT_STOP = 2;
    localparam int ACT_W    = 3;

endpackage

// File: rtl/pwm_tick_src.sv
module pwm_tick_src #(
    parameter int PS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_in,
    input  logic            sel_cap,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] ps_lim,
    output logic [PS_W-1:0] ps_cnt,
    output logic            adv
);

    localparam int SYNC_N = 3;

    logic [SYNC_N-1:0] sync_q;
    logic              cap_rise;
    logic              tick;
    logic              at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], cap_in};
    end

    assign cap_rise = sync_q[SYNC_N-2] & ~sync_q[SYNC_N-1];
    assign tick     = sel_cap ? cap_rise : 1'b1;
    assign at_lim   = (ps_cnt == ps_lim);
    assign adv      = run & tick & at_lim & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ps_cnt <= '0;
        else if (clr)        ps_cnt <= '0;
        else if (run & tick) ps_cnt <= at_lim ? '0 : ps_cnt + 1'b1;
    end

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int N_MATCH = 7,
    parameter int DW      = 32,
    localparam int IW     = $clog2(N_MATCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IW-1:0]               wr_idx,
    input  logic [DW-1:0]               wr_data,
    input  logic [N_MATCH-1:0]          rel_set,
    input  logic                        xfer_ok,
    input  logic [DW-1:0]               count,
    output logic [N_MATCH-1:0][DW-1:0]  shadow_q,
    output logic [N_MATCH-1:0][DW-1:0]  active_q,
    output logic [N_MATCH-1:0]          rel_q,
    output logic [N_MATCH-1:0]          hit
);

    logic [N_MATCH-1:0] take;

    assign take = rel_q & {N_MATCH{xfer_ok}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
            rel_q    <= '0;
        end else begin
            for (int i = 0; i < N_MATCH; i++) begin
                if (wr_en && (wr_idx == IW'(i))) shadow_q[i] <= wr_data;
                if (take[i])                      active_q[i] <= shadow_q[i];
            end
            rel_q <= (rel_q & ~take) | rel_set;
        end
    end

    for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
        assign hit[g] = (count == active_q[g]);
    end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int N_OUT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_en,
    input  logic             cyc_start,
    input  logic [N_OUT:0]   ev,
    input  logic [N_OUT-1:1] dbl,
    output logic [N_OUT-1:0] pwm_out
);

    logic [N_OUT-1:0] set_v;
    logic [N_OUT-1:0] clr_v;

    for (genvar j = 0; j < N_OUT; j++) begin : g_ch
        if (j == 0) begin : g_single_only
            assign set_v[j] = cyc_start;
        end else begin : g_selectable
            assign set_v[j] = dbl[j] ? ev[j] : cyc_start;
        end
        assign clr_v[j] = ev[j+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_out <= '0;
        end else begin
            for (int j = 0; j < N_OUT; j++) begin
                if (!pwm_en)       pwm_out[j] <= 1'b0;
                else if (clr_v[j]) pwm_out[j] <= 1'b0;
                else if (set_v[j]) pwm_out[j] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int DW    = 32,
    parameter int N_OUT = 6,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             cap_in,
    output logic [N_OUT-1:0] pwm_out,
    output logic             irq
);

    localparam int N_MATCH = N_OUT + 1;
    localparam int IW      = $clog2(N_MATCH);
    localparam int CFG_W   = ACT_W * N_MATCH;

    localparam logic [AW-1:0] A_CTRL  = AW'(0);
    localparam logic [AW-1:0] A_PSLIM = AW'(1);
    localparam logic [AW-1:0] A_COUNT = AW'(2);
    localparam logic [AW-1:0] A_PSCNT = AW'(3);
    localparam logic [AW-1:0] A_ACT   = AW'(4);
    localparam logic [AW-1:0] A_EDGE  = AW'(5);
    localparam logic [AW-1:0] A_REL   = AW'(6);
    localparam logic [AW-1:0] A_IRQ   = AW'(7);
    localparam logic [AW-1:0] A_SHD   = AW'(8);
    localparam logic [AW-1:0] A_ACTV  = AW'(16);

    // control and configuration
    logic                ctrl_en, ctrl_clr, ctrl_pwm, ctrl_sel;
    logic [DW-1:0]       ps_lim;
    logic [CFG_W-1:0]    act_cfg;
    logic [N_OUT-1:1]    dbl_q;
    logic [N_MATCH-1:0]  irq_flags;

    // datapath
    logic [DW-1:0]                count;
    logic [DW-1:0]                ps_cnt;
    logic                         adv;
    logic [N_MATCH-1:0]           hit, ev, ev_irq;
    logic [N_MATCH-1:0]           int_bits, rst_bits, stop_bits;
    logic [N_MATCH-1:0][DW-1:0]   shadow_q, active_q;
    logic [N_MATCH-1:0]           rel_q, rel_set;
    logic                         stop_ev, rst_ev, cyc_start, xfer_ok;

    // state machine
    tmr_state_e state_q, state_d;
    logic       run_s, halted_s;

    // bus decode
    logic          in_shd, in_actv, sh_we;
    logic [IW-1:0] sh_idx, av_idx;

    assign in_shd  = (bus_addr >= A_SHD)  && (bus_addr < A_SHD  + AW'(N_MATCH));
    assign in_actv = (bus_addr >= A_ACTV) && (bus_addr < A_ACTV + AW'(N_MATCH));
    assign sh_we   = bus_we && in_shd;
    assign sh_idx  = IW'(bus_addr - A_SHD);
    assign av_idx  = IW'(bus_addr - A_ACTV);
    assign rel_set = (bus_we && bus_addr == A_REL) ? bus_wdata[N_MATCH-1:0] : '0;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cfg
        assign int_bits[i]  = act_cfg[ACT_W*i + ACT_INT];
        assign rst_bits[i]  = act_cfg[ACT_W*i + ACT_RST];
        assign stop_bits[i] = act_cfg[ACT_W*i + ACT_STOP];
    end

    assign ev        = hit & {N_MATCH{adv}};
    assign ev_irq    = ev & int_bits;
    assign stop_ev   = |(ev & stop_bits);
    assign rst_ev    = |(ev & rst_bits);
    assign cyc_start = ev[0] & ctrl_pwm;
    assign xfer_ok   = (state_q != ST_RUN) || ev[0];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_en)      state_d = ST_RUN;
            ST_RUN:  if (!ctrl_en)     state_d = ST_IDLE;
                     else if (stop_ev) state_d = ST_HALT;
            ST_HALT: if (!ctrl_en)     state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        run_s    = 1'b0;
        halted_s = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  run_s    = 1'b1;
            ST_HALT: halted_s = 1'b1;
            default: ;
        endcase
    end

    // ---------------- submodules ----------------
    pwm_tick_src #(.PS_W(DW)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .sel_cap (ctrl_sel),
        .run     (run_s),
        .clr     (ctrl_clr),
        .ps_lim  (ps_lim),
        .ps_cnt  (ps_cnt),
        .adv     (adv)
    );

    pwm_match_bank #(.N_MATCH(N_MATCH), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sh_we),
        .wr_idx   (sh_idx),
        .wr_data  (bus_wdata),
        .rel_set  (rel_set),
        .xfer_ok  (xfer_ok),
        .count    (count),
        .shadow_q (shadow_q),
        .active_q (active_q),
        .rel_q    (rel_q),
        .hit      (hit)
    );

    pwm_out_stage #(.N_OUT(N_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_en    (ctrl_pwm),
        .cyc_start (cyc_start),
        .ev        (ev),
        .dbl       (dbl_q),
        .pwm_out   (pwm_out)
    );

    // ---------------- counter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (ctrl_clr)              count <= '0;
        else if (adv) begin
            if (rst_ev || cyc_start)    count <= '0;
            else if (!stop_ev)          count <= count + 1'b1;
        end
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {ctrl_sel, ctrl_pwm, ctrl_clr, ctrl_en} <= '0;
            ps_lim    <= '0;
            act_cfg   <= '0;
            dbl_q     <= '0;
            irq_flags <= '0;
        end else begin
            if (bus_we) begin
                unique case (bus_addr)
                    A_CTRL:  {ctrl_sel, ctrl_pwm, ctrl_clr, ctrl_en} <= bus_wdata[3:0];
                    A_PSLIM: ps_lim  <= bus_wdata;
                    A_ACT:   act_cfg <= bus_wdata[CFG_W-1:0];
                    A_EDGE:  dbl_q   <= bus_wdata[N_OUT-1:1];
                    default: ;
                endcase
            end
            irq_flags <= (irq_flags & ~((bus_we && bus_addr == A_IRQ) ?
                          bus_wdata[N_MATCH-1:0] : '0)) | ev_irq;
        end
    end

    assign irq = |irq_flags;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (in_shd) begin
            bus_rdata = shadow_q[sh_idx];
        end else if (in_actv) begin
            bus_rdata = active_q[av_idx];
        end else begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata = {{(DW-4){1'b0}}, ctrl_sel, ctrl_pwm, ctrl_clr, ctrl_en};
                A_PSLIM: bus_rdata = ps_lim;
                A_COUNT: bus_rdata = count;
                A_PSCNT: bus_rdata = ps_cnt;
                A_ACT:   bus_rdata = {{(DW-CFG_W){1'b0}}, act_cfg};
                A_EDGE:  bus_rdata = {{(DW-N_OUT){1'b0}}, dbl_q, 1'b0};
                A_REL:   bus_rdata = {{(DW-N_MATCH){1'b0}}, rel_q};
                A_IRQ:   bus_rdata = {{(DW-N_MATCH){1'b0}}, irq_flags};
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int DW    = 32,
    parameter int N_OUT = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pwm_en,
    input logic                     adv,
    input logic                     cnt_clr,
    input logic                     halted,
    input logic                     hit0,
    input logic                     xfer_ok,
    input logic [DW-1:0]            count,
    input logic [N_OUT:0]           ev,
    input logic [N_OUT:0]           ev_irq,
    input logic [N_OUT:0][DW-1:0]   active,
    input logic                     irq,
    input logic [N_OUT-1:0]         pwm_out
);

    a_r2_count_moves_on_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cnt_clr) |=> $stable(count));

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pwm_en && hit0) |=> (count == '0));

    a_r9_active_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_ok |=> $stable(active));

    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !cnt_clr) |=> $stable(count));

    a_r12_irq_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_irq) |=> irq);

    a_r13_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> (pwm_out == '0));

    for (genvar j = 0; j < N_OUT; j++) begin : g_prio
        a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_en && ev[j+1]) |=> !pwm_out[j]);
    end

endmodule

bind pwm_timer pwm_timer_chk #(.DW(DW), .N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_en  (ctrl_pwm),
    .adv     (adv),
    .cnt_clr (ctrl_clr),
    .halted  (halted_s),
    .hit0    (hit[0]),
    .xfer_ok (xfer_ok),
    .count   (count),
    .ev      (ev),
    .ev_irq  (ev_irq),
    .active  (active_q),
    .irq     (irq),
    .pwm_out (pwm_out)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_in = 1'b0;
    logic [5:0]  pwm_out;
    logic        irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    pwm_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // ---- bench model of the output rules (R5, R6, R7) ----
    int         m[7];
    logic [5:0] dblm;
    logic [5:0] mo;

    function automatic logic [5:0] apply_events(input logic [5:0] cur, input int p);
        logic [5:0] nx = cur;
        for (int k = 1; k <= 6; k++) begin
            bit clr_e = (m[k] == p);
            bit set_e = (k > 1 && dblm[k-1]) ? (m[k-1] == p) : (p == m[0]);
            if (clr_e)      nx[k-1] = 1'b0;
            else if (set_e) nx[k-1] = 1'b1;
        end
        return nx;
    endfunction

    task automatic random_run();
        logic [31:0] c;
        int pr, prev, maxc, len;
        int mism[6];
        m[0] = $urandom_range(15, 3);
        pr   = $urandom_range(2, 0);
        for (int k = 1; k <= 6; k++) m[k] = $urandom_range(m[0] + 2, 0);
        dblm = 6'($urandom_range(63, 0));
        wr(0, 32'h2);
        for (int i = 0; i < 7; i++) wr(5'(8 + i), 32'(m[i]));
        wr(6, 32'h7F);
        wr(4, 0);
        wr(5, {26'd0, dblm});
        wr(1, 32'(pr));
        wr(0, 32'h5);
        mo = '0; prev = 0; maxc = 0;
        for (int j = 0; j < 6; j++) mism[j] = 0;
        len = (m[0] + 1) * (pr + 1);
        for (int t = 0; t < 4 * len + 8; t++) begin
            rd(2, c);
            if (int'(c) != prev) begin
                mo = apply_events(mo, prev);
                prev = int'(c);
            end
            if (int'(c) > maxc) maxc = int'(c);
            for (int j = 0; j < 6; j++) if (pwm_out[j] != mo[j]) mism[j]++;
            @(negedge clk);
        end
        chk("R4 period top", maxc, m[0]);
        for (int j = 0; j < 6; j++)
            chk((j > 0 && dblm[j]) ? "R6 double-edge channel" : "R5 single-edge channel",
                mism[j], 0);
    endtask

    initial begin
        logic [31:0] d, c, a;
        int bad, nchg, lastc, lastt, maxc, hi_cnt, wraps;
        bit seen;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, d);  chk("R1 ctrl", d, 0);
        rd(2, d);  chk("R1 count", d, 0);
        rd(6, d);  chk("R1 release", d, 0);
        rd(7, d);  chk("R1 flags", d, 0);
        rd(17, d); chk("R1 active", d, 0);
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 irq", irq, 0);

        // R2 prescaler on clock source
        wr(0, 2); wr(1, 3); wr(8, 1000); wr(6, 1); wr(4, 0); wr(0, 1);
        bad = 0; nchg = 0; lastc = 0; lastt = 0;
        for (int t = 0; t < 48; t++) begin
            rd(2, c);
            if (int'(c) != lastc) begin
                if (int'(c) != lastc + 1) bad++;
                if (nchg > 0 && t - lastt != 4) bad++;
                nchg++; lastt = t; lastc = int'(c);
            end
            @(negedge clk);
        end
        chk("R2 step spacing", bad, 0);
        chk("R2 advanced", nchg >= 10, 1);

        // R3 capture pin source
        wr(0, 2); wr(1, 0); wr(0, 9);
        for (int p = 0; p < 5; p++) begin
            cap_in = 1'b1; repeat (3) @(negedge clk);
            cap_in = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(2, d); chk("R3 edge count", d, 5);
        cap_in = 1'b1; repeat (20) @(negedge clk);
        rd(2, d); chk("R3 level counts once", d, 6);
        cap_in = 1'b0;

        // R9 release while running
        wr(0, 2); wr(4, 0); wr(5, 0); wr(8, 9); wr(9, 3); wr(6, 3); wr(0, 5);
        repeat (25) @(negedge clk);
        wr(9, 5);
        repeat (25) @(negedge clk);
        rd(17, d); chk("R9 unreleased active kept", d, 3);
        rd(9, d);  chk("R9 shadow readback", d, 5);
        wr(6, 2);
        rd(6, d);  chk("R9 release pending", d, 2);
        seen = 1'b0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            rd(17, a);
            if (a == 5 && !seen) begin
                seen = 1'b1;
                rd(2, c); chk("R9 transfer at wrap", c, 0);
            end
        end
        chk("R9 transfer happened", seen, 1);
        rd(6, d); chk("R9 release self-clear", d, 0);

        // R10 reset action, R13 timer mode
        wr(0, 2); wr(8, 1000); wr(10, 5); wr(6, 5); wr(4, 32'h80); wr(0, 1);
        maxc = 0; hi_cnt = 0; wraps = 0; lastc = 0;
        for (int t = 0; t < 40; t++) begin
            rd(2, c);
            if (int'(c) > maxc) maxc = int'(c);
            if (lastc == 5 && c == 0) wraps++;
            lastc = int'(c);
            if (pwm_out != 0) hi_cnt++;
            @(negedge clk);
        end
        chk("R10 reset action max", maxc, 5);
        chk("R10 reset action wraps", wraps >= 2, 1);
        chk("R13 outputs low in timer mode", hi_cnt, 0);

        // R11 stop action, R9 transfer when halted
        wr(0, 2); wr(11, 7); wr(6, 8); wr(4, 32'h800); wr(0, 1);
        repeat (30) @(negedge clk);
        rd(2, d); chk("R11 stopped at match", d, 7);
        repeat (20) @(negedge clk);
        rd(2, d); chk("R11 still stopped", d, 7);
        wr(11, 20); wr(6, 8);
        @(negedge clk);
        rd(19, d); chk("R9 halted transfer next clock", d, 20);

        // R12 interrupt action
        wr(0, 2); wr(7, 32'h7F); wr(9, 4); wr(6, 2); wr(4, 32'h8); wr(0, 1);
        chk("R12 irq low before match", irq, 0);
        for (int t = 0; t < 30; t++) begin
            rd(2, c);
            if (c >= 5) break;
            @(negedge clk);
        end
        chk("R12 irq raised", irq, 1);
        rd(7, d); chk("R12 flag bit", d, 2);
        wr(0, 2); wr(7, 2);
        chk("R12 irq cleared", irq, 0);
        rd(7, d); chk("R12 flag cleared", d, 0);

        // R7 / R8 priority and output 1 mode
        wr(0, 2); wr(4, 0);
        wr(8, 8); wr(9, 8); wr(10, 4); wr(11, 4); wr(12, 20); wr(6, 32'h1F);
        wr(5, 32'h05);
        rd(5, d); chk("R8 edge bit0 ignored", d, 4);
        wr(1, 0); wr(0, 5);
        repeat (30) @(negedge clk);
        bad = 0; hi_cnt = 0; nchg = 0;
        for (int t = 0; t < 20; t++) begin
            if (pwm_out[0]) bad++;
            if (pwm_out[2]) hi_cnt++;
            if (!pwm_out[3]) nchg++;
            @(negedge clk);
        end
        chk("R8 R7 output1 single, match equals period", bad, 0);
        chk("R7 double equal edges stay low", hi_cnt, 0);
        chk("R7 match above period stays high", nchg, 0);

        // random mixes for R4 R5 R6
        for (int it = 0; it < 12; it++) random_run();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule